// File: doc/BRIEF.md
# Stepped-Phase Square Reference Generator

This block produces the two sign references that a multiplier-free lock-in demodulator mixes with its samples. It is meant for the case where the sample rate is a rational multiple 4N/α of the signal frequency and not an integer multiple of four times it. The block keeps a phase index in the range 0 to 4N−1. Each sample strobe moves the index forward by α, wrapping modulo 4N. The index is compared with the quarter points N, 2N and 3N to give an in-phase sign and a quadrature sign, each one bit wide. The downstream accumulator then adds the sample or subtracts it, and needs no multiplier.

A measurement opens with a synchronous start, which returns the phase to zero. The demodulator then presents one strobe per sample. The block also outputs the index of each sample and a one-cycle flag on every sample whose index came about by wrapping past 4N. Downstream logic can count reference periods with that flag. The configuration values N and α are held steady during a measurement, and α must be below 2N.

Top module: `stepref_gen`

## Requirements
- R1: When reset is released, the index output is 0, both sign outputs are 0 and the wrap flag is 0.
- R2: Counting the strobes after a start or reset from n = 0, the index output in the cycle after strobe n equals (α·n) mod 4N. The first sample therefore uses index 0.
- R3: The in-phase sign bit encodes +1 as 0 and −1 as 1. It is 0 when the sample's index is below 2N and 1 when the index lies from 2N to 4N−1.
- R4: The quadrature sign bit uses the same encoding. It is 0 when the index is below N or is 3N or more, and 1 when the index lies from N to 3N−1.
- R5: All outputs change only in the cycle after a strobe or a start. On a cycle with neither, the index and both signs hold their values and the wrap flag is 0.
- R6: The wrap flag is 1 for exactly one cycle, the cycle after the strobe of a sample whose index was reached by passing 4N and subtracting 4N. It is 0 otherwise, including for the first sample after a start.
- R7: A start clears the phase, so the next cycle shows index 0, signs 0 and wrap 0. If a strobe arrives in the same cycle as a start, the start takes precedence and the strobe does not advance the phase.
- R8: Whenever α is below 2N, the index output stays below 4N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous measurement start, clears the phase |
| sample_en | input | 1 | One-cycle strobe per input sample |
| cfg_n | input | NW | Quarter-period length N |
| cfg_alpha | input | NW+1 | Phase step α, below 2N |
| ref_i_neg | output | 1 | In-phase sign, 1 means −1 |
| ref_q_neg | output | 1 | Quadrature sign, 1 means −1 |
| phase_idx | output | NW+2 | Index of the latest sample |
| wrap | output | 1 | Pulses on a sample reached by wrapping |

## Verification
A wrong accumulator value shows on phase_idx in the cycle after the next strobe. From there it corrupts every later index, so comparing against a model on every cycle catches it at the first affected sample. A faulty wrap subtraction shows up in two ways: the index can jump out of range, or the wrap flag can appear on the wrong sample. Either is visible one cycle after that sample's strobe. Threshold errors show only on samples whose index lies next to N, 2N or 3N. For that reason the test runs several (N, α) pairs, both coprime and non-coprime, which together place samples on every boundary.

// File: rtl/stepref_pkg.sv
package stepref_pkg;

    // Default width of the quarter-period configuration
    parameter int DEF_NW = 8;

    // Sign encoding shared by the datapath
    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } sign_e;

    // In-phase and quadrature sign pair for one sample
    typedef struct packed {
        sign_e i;
        sign_e q;
    } ref_pair_t;

    localparam ref_pair_t REF_PAIR_IDLE = '{i: SGN_POS, q: SGN_POS};

endpackage

// File: rtl/stepref_span.sv
module stepref_span #(
    parameter int NW = stepref_pkg::DEF_NW,
    localparam int IW = NW + 2
) (
    input  logic [NW-1:0] cfg_n,
    output logic [IW-1:0] lim_q1,
    output logic [IW-1:0] lim_half,
    output logic [IW-1:0] lim_q3,
    output logic [IW-1:0] lim_full
);

    // Quarter points of the 4N-long reference period
    always_comb begin
        lim_q1   = {2'b00, cfg_n};
        lim_half = {1'b0, cfg_n, 1'b0};
        lim_full = {cfg_n, 2'b00};
        lim_q3   = lim_q1 + lim_half;
    end

endmodule

// File: rtl/stepref_accum.sv
module stepref_accum #(
    parameter int NW = stepref_pkg::DEF_NW,
    localparam int IW = NW + 2,
    localparam int AW = NW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sample_en,
    input  logic [AW-1:0] alpha,
    input  logic [IW-1:0] lim_full,
    output logic [IW-1:0] acc_idx,
    output logic          acc_wrapped
);

    logic [IW-1:0] acc_q;
    logic          wrapped_q;
    logic [IW:0]   sum_w;
    logic [IW:0]   red_w;
    logic          over_w;
    logic [IW-1:0] next_w;

    // One conditional subtraction suffices because alpha is below 2N
    always_comb begin
        sum_w  = {1'b0, acc_q} + {{(IW + 1 - AW){1'b0}}, alpha};
        over_w = (sum_w >= {1'b0, lim_full});
        red_w  = sum_w - {1'b0, lim_full};
        next_w = over_w ? red_w[IW-1:0] : sum_w[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc_q     <= '0;
            wrapped_q <= 1'b0;
        end else if (sample_en) begin
            acc_q     <= next_w;
            wrapped_q <= over_w;
        end
    end

    assign acc_idx     = acc_q;
    assign acc_wrapped = wrapped_q;

endmodule

// File: rtl/stepref_slicer.sv
module stepref_slicer
    import stepref_pkg::*;
#(
    parameter int NW = stepref_pkg::DEF_NW,
    localparam int IW = NW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sample_en,
    input  logic [IW-1:0] idx_in,
    input  logic          wrapped_in,
    input  logic [IW-1:0] lim_q1,
    input  logic [IW-1:0] lim_half,
    input  logic [IW-1:0] lim_q3,
    output logic [IW-1:0] idx_out,
    output ref_pair_t     pair_out,
    output logic          wrap_out
);

    ref_pair_t     pair_w;
    ref_pair_t     pair_q;
    logic [IW-1:0] idx_q;
    logic          wrap_q;

    always_comb begin
        pair_w.i = (idx_in >= lim_half) ? SGN_NEG : SGN_POS;
        pair_w.q = ((idx_in >= lim_q1) && (idx_in < lim_q3)) ? SGN_NEG : SGN_POS;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            idx_q  <= '0;
            pair_q <= REF_PAIR_IDLE;
            wrap_q <= 1'b0;
        end else if (sample_en) begin
            idx_q  <= idx_in;
            pair_q <= pair_w;
            wrap_q <= wrapped_in;
        end else begin
            wrap_q <= 1'b0;
        end
    end

    assign idx_out  = idx_q;
    assign pair_out = pair_q;
    assign wrap_out = wrap_q;

endmodule

// File: rtl/stepref_gen.sv
module stepref_gen
    import stepref_pkg::*;
#(
    parameter int NW = stepref_pkg::DEF_NW,
    localparam int IW = NW + 2,
    localparam int AW = NW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sample_en,
    input  logic [NW-1:0] cfg_n,
    input  logic [AW-1:0] cfg_alpha,
    output logic          ref_i_neg,
    output logic          ref_q_neg,
    output logic [IW-1:0] phase_idx,
    output logic          wrap
);

    logic [IW-1:0] lim_q1;
    logic [IW-1:0] lim_half;
    logic [IW-1:0] lim_q3;
    logic [IW-1:0] lim_full;
    logic [IW-1:0] acc_idx;
    logic          acc_wrapped;
    ref_pair_t     pair;

    stepref_span #(.NW(NW)) span_i (
        .cfg_n    (cfg_n),
        .lim_q1   (lim_q1),
        .lim_half (lim_half),
        .lim_q3   (lim_q3),
        .lim_full (lim_full)
    );

    stepref_accum #(.NW(NW)) accum_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sample_en   (sample_en),
        .alpha       (cfg_alpha),
        .lim_full    (lim_full),
        .acc_idx     (acc_idx),
        .acc_wrapped (acc_wrapped)
    );

    stepref_slicer #(.NW(NW)) slicer_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sample_en  (sample_en),
        .idx_in     (acc_idx),
        .wrapped_in (acc_wrapped),
        .lim_q1     (lim_q1),
        .lim_half   (lim_half),
        .lim_q3     (lim_q3),
        .idx_out    (phase_idx),
        .pair_out   (pair),
        .wrap_out   (wrap)
    );

    assign ref_i_neg = pair.i;
    assign ref_q_neg = pair.q;

endmodule

// File: rtl/stepref_chk.sv
module stepref_chk #(
    parameter int NW = stepref_pkg::DEF_NW,
    localparam int IW = NW + 2,
    localparam int AW = NW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          sample_en,
    input logic [NW-1:0] cfg_n,
    input logic [AW-1:0] cfg_alpha,
    input logic          ref_i_neg,
    input logic          ref_q_neg,
    input logic [IW-1:0] phase_idx,
    input logic          wrap
);

    logic [IW+1:0] n_x;
    assign n_x = {4'b0000, cfg_n};

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (rst || start)
        ({3'b000, cfg_alpha} < 2 * n_x) |-> ({2'b00, phase_idx} < 4 * n_x));

    assert_i_sign_R3: assert property (@(posedge clk) disable iff (rst || start)
        ref_i_neg == ({2'b00, phase_idx} >= 2 * n_x));

    assert_q_sign_R4: assert property (@(posedge clk) disable iff (rst || start)
        ref_q_neg == (({2'b00, phase_idx} >= n_x) && ({2'b00, phase_idx} < 3 * n_x)));

    assert_wrap_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |-> $past(sample_en));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !start) |=> ($stable(phase_idx) && $stable(ref_i_neg) &&
                                    $stable(ref_q_neg) && !wrap));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase_idx == '0 && !wrap && !ref_i_neg && !ref_q_neg));

endmodule

bind stepref_gen stepref_chk #(.NW(NW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sample_en (sample_en),
    .cfg_n     (cfg_n),
    .cfg_alpha (cfg_alpha),
    .ref_i_neg (ref_i_neg),
    .ref_q_neg (ref_q_neg),
    .phase_idx (phase_idx),
    .wrap      (wrap)
);

// File: tb/stepref_gen_tb_top.sv
module stepref_gen_tb_top;

    localparam int NW = 8;
    localparam int IW = NW + 2;
    localparam int AW = NW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          sample_en = 1'b0;
    logic [NW-1:0] cfg_n = 8'd3;
    logic [AW-1:0] cfg_alpha = 9'd1;
    logic          ref_i_neg;
    logic          ref_q_neg;
    logic [IW-1:0] phase_idx;
    logic          wrap;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Behavioural model state
    int m_acc = 0;
    bit m_pend = 0;
    int e_idx = 0;
    bit e_i = 0;
    bit e_q = 0;
    bit e_w = 0;

    always #5 clk = ~clk;

    stepref_gen #(.NW(NW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sample_en (sample_en),
        .cfg_n     (cfg_n),
        .cfg_alpha (cfg_alpha),
        .ref_i_neg (ref_i_neg),
        .ref_q_neg (ref_q_neg),
        .phase_idx (phase_idx),
        .wrap      (wrap)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit r, input bit st, input bit se);
        int n4;
        int nxt;
        n4 = 4 * int'(cfg_n);
        if (r || st) begin
            m_acc = 0; m_pend = 0;
            e_idx = 0; e_i = 0; e_q = 0; e_w = 0;
        end else if (se) begin
            e_idx = m_acc;
            e_i = (m_acc >= 2 * int'(cfg_n));
            e_q = (m_acc >= int'(cfg_n)) && (m_acc < 3 * int'(cfg_n));
            e_w = m_pend;
            nxt = m_acc + int'(cfg_alpha);
            m_pend = (nxt >= n4);
            m_acc = m_pend ? nxt - n4 : nxt;
        end else begin
            e_w = 0;
        end
    endtask

    // Drive at the falling edge, step the model at the rising edge, compare at the next falling edge
    task automatic tick(input bit st, input bit se);
        start = st;
        sample_en = se;
        @(posedge clk);
        model_edge(rst, st, se);
        @(negedge clk);
        if (st) begin
            check("R7 index", int'(phase_idx), e_idx);
            check("R7 wrap", int'(wrap), int'(e_w));
        end else begin
            check(se ? "R2 index" : "R5 index", int'(phase_idx), e_idx);
            check("R6 wrap", int'(wrap), int'(e_w));
        end
        check("R3 in-phase sign", int'(ref_i_neg), int'(e_i));
        check("R4 quadrature sign", int'(ref_q_neg), int'(e_q));
        check("R8 range", int'(phase_idx < IW'(4 * int'(cfg_n))), 1);
        start = 1'b0;
        sample_en = 1'b0;
    endtask

    task automatic run_cfg(input int n, input int a, input int samples, input bit gaps);
        cfg_n = NW'(n);
        cfg_alpha = AW'(a);
        tick(1'b1, 1'b0);
        for (int k = 0; k < samples; k++) begin
            tick(1'b0, 1'b1);
            if (gaps) begin
                for (int g = 0; g < (k % 3); g++) tick(1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 index", int'(phase_idx), 0);
        check("R1 in-phase sign", int'(ref_i_neg), 0);
        check("R1 quadrature sign", int'(ref_q_neg), 0);
        check("R1 wrap", int'(wrap), 0);

        // R2 plain integer multiple, alpha = 1
        run_cfg(3, 1, 30, 1'b0);
        // coprime step
        run_cfg(5, 3, 45, 1'b1);
        // step sharing a factor with 4N
        run_cfg(6, 4, 40, 1'b0);
        // largest legal step, alpha = 2N-1
        run_cfg(4, 7, 36, 1'b1);
        run_cfg(1, 1, 12, 1'b0);

        // R7: start mid-run together with a strobe
        run_cfg(5, 3, 9, 1'b0);
        tick(1'b1, 1'b1);
        check("R7 index after start+strobe", int'(phase_idx), 0);
        tick(1'b0, 1'b1);
        check("R7 first sample index 0", int'(phase_idx), 0);
        tick(1'b0, 1'b1);
        check("R2 second sample index", int'(phase_idx), 3);
        for (int k = 0; k < 20; k++) tick(1'b0, 1'b1);

        // R1: reset mid-run returns to the idle state
        rst = 1'b1;
        tick(1'b0, 1'b1);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        check("R1 index after reset", int'(phase_idx), 0);
        for (int k = 0; k < 10; k++) tick(1'b0, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule